// File: doc/BRIEF.md
# Memory-Mapped Device Controller with Busy/Done Handshake

This block is the register front end of a slow peripheral. A processor reaches it through a word-addressed bus in which a read or a write completes in the cycle it is presented. Software stages operand words in a small bank of data registers and then writes an operation code into the command register. The controller marks itself busy while the modelled device runs. After a fixed, parameterised number of cycles it drops busy, raises done and asserts an interrupt-pending line. The interrupt handler finishes the exchange by writing a zero into the done bit, which returns the controller to idle and withdraws the interrupt.

The controller has three named states. `ST_IDLE` reports status 00. `ST_WORK` reports busy=1, done=0. `ST_DONE` reports busy=0, done=1. The transitions are as follows. *accept* goes from `ST_IDLE` to `ST_WORK` on a valid command write. *expire* goes from `ST_WORK` to `ST_DONE` when the operation timer runs out. *release* goes from `ST_DONE` to `ST_IDLE` when software writes done=0. The busy/done pair 11 belongs to no state. A READ operation deposits a fixed pattern in data register 0 as it completes. A WRITE operation only consumes time. Command writes that arrive in the wrong state, and unknown command codes, are dropped and leave a code in the status error field.

Top module: `devctl_regs`

Word address map: 0 command, 1 status, 2 to 2+NUM_DATA-1 data registers 0 to NUM_DATA-1.

Status word layout: bit 0 done, bit 1 busy, bits 3:2 error code (0 none, 1 command while not idle, 2 unknown command), all other bits read 0.

Command codes: 1 = READ, 2 = WRITE.

## Requirements
- R1: After reset, every mapped register reads 0, the status reads 0 (idle, no error) and irq_pending is 0.
- R2: In idle, a write of 1 or 2 to address 0 is accepted: from the next cycle the status shows busy=1 and done=0, the error field reads 0, and address 0 reads back the accepted code.
- R3: After acceptance, busy stays 1 for exactly OP_CYCLES cycles and then status becomes busy=0, done=1; the pair busy=1 with done=1 never appears.
- R4: irq_pending rises in the same cycle that busy falls and done rises, and stays 1 while done is 1.
- R5: In the done state, a status write with bit 0 = 0 returns the status to idle (00) and clears irq_pending in the next cycle; a status write with bit 0 = 1 changes nothing.
- R6: A command write while busy or done is ignored: the state, the timer and the stored command are kept, and the error field becomes 1.
- R7: In idle, a command write with any code other than 1 or 2 is ignored (the state stays idle) and the error field becomes 2.
- R8: When a READ completes, data register 0 takes the value READ_PATTERN, and this takes priority over a bus write to it in the same cycle; a completing WRITE leaves all data registers unchanged.
- R9: A write to data address 2+i stores the word in data register i, and it reads back in any state; reads of addresses that are not mapped return 0.
- R10: Status writes while idle or busy do not change busy or done.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Register write strobe for the current address |
| addr | input | ADDR_W | Word address of the access |
| wr_data | input | DW | Write data |
| rd_data | output | DW | Read data for `addr`, valid in the same cycle |
| irq_pending | output | 1 | Interrupt pending, set when an operation completes |

## Verification
The bench builds the block with OP_CYCLES=5, NUM_DATA=4, ADDR_W=3 and a non-default READ_PATTERN. With these values a complete accept-expire-release round trip takes only a handful of cycles, so several can be run back to back. They also leave addresses 6 and 7 unmapped, which lets the bench check the zero readback. With this duration a command, a status write and a data write can each land inside the busy window. A data write can also coincide with the completing cycle of a READ, which exercises the fill priority.

// File: rtl/devctl_pkg.sv
package devctl_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_WORK = 2'd1,
        ST_DONE = 2'd2
    } dev_state_e;

    localparam int unsigned CMD_READ  = 1;
    localparam int unsigned CMD_WRITE = 2;

    localparam logic [1:0] ERR_NONE   = 2'd0;
    localparam logic [1:0] ERR_BUSY   = 2'd1;
    localparam logic [1:0] ERR_BADCMD = 2'd2;

    localparam int unsigned ADDR_CMD  = 0;
    localparam int unsigned ADDR_STAT = 1;
    localparam int unsigned DATA_BASE = 2;

endpackage

// File: rtl/devctl_fsm.sv
module devctl_fsm
    import devctl_pkg::*;
#(
    parameter int DW        = 16,
    parameter int OP_CYCLES = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cmd_wr,
    input  logic [DW-1:0] cmd_code,
    input  logic          stat_wr,
    input  logic          stat_done_wr,
    output logic          busy,
    output logic          done,
    output logic          irq_pending,
    output logic [1:0]    err_code,
    output logic [DW-1:0] cur_cmd,
    output logic          fill_rd
);

    localparam int CW = (OP_CYCLES > 1) ? $clog2(OP_CYCLES) : 1;
    localparam logic [CW-1:0] CNT_LOAD = CW'(OP_CYCLES - 1);

    dev_state_e    state_q, state_d;
    logic [CW-1:0] cnt_q;
    logic          cmd_ok, accept, expire, release_done;

    assign cmd_ok       = (cmd_code == DW'(CMD_READ)) || (cmd_code == DW'(CMD_WRITE));
    assign accept       = cmd_wr && (state_q == ST_IDLE) && cmd_ok;
    assign expire       = (state_q == ST_WORK) && (cnt_q == '0);
    assign release_done = stat_wr && !stat_done_wr && (state_q == ST_DONE);

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (accept)       state_d = ST_WORK;
            ST_WORK: if (expire)       state_d = ST_DONE;
            ST_DONE: if (release_done) state_d = ST_IDLE;
            default:                   state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q       <= '0;
            irq_pending <= 1'b0;
            err_code    <= ERR_NONE;
            cur_cmd     <= '0;
        end else begin
            if (accept)
                cnt_q <= CNT_LOAD;
            else if ((state_q == ST_WORK) && !expire)
                cnt_q <= cnt_q - 1'b1;

            if (expire)
                irq_pending <= 1'b1;
            else if (release_done)
                irq_pending <= 1'b0;

            if (cmd_wr) begin
                if (state_q != ST_IDLE) err_code <= ERR_BUSY;
                else if (cmd_ok)        err_code <= ERR_NONE;
                else                    err_code <= ERR_BADCMD;
            end

            if (accept)
                cur_cmd <= cmd_code;
        end
    end

    assign busy    = (state_q == ST_WORK);
    assign done    = (state_q == ST_DONE);
    assign fill_rd = expire && (cur_cmd == DW'(CMD_READ));

    a_r2_accept_sets_busy: assert property (@(posedge clk) disable iff (!rst_n)
        accept |=> busy && !done && (err_code == ERR_NONE));

    a_r3_finish_after_count: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && cnt_q == '0) |=> done && !busy);

    a_r3_count_in_range: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> (cnt_q <= CNT_LOAD));

    a_r4_irq_with_done: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(done) |-> irq_pending);

    a_r5_release_clears: assert property (@(posedge clk) disable iff (!rst_n)
        release_done |=> !irq_pending && !busy && !done);

    a_r6_reject_when_active: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_wr && (busy || done)) |=> (err_code == ERR_BUSY) && $stable(cur_cmd));

    a_r7_bad_code_stays_idle: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_wr && !busy && !done && !cmd_ok) |=> !busy && !done && (err_code == ERR_BADCMD));

    a_r10_status_write_inert: assert property (@(posedge clk) disable iff (!rst_n)
        (stat_wr && !done && !expire) |=> $stable(busy) || (done && !busy));

endmodule

// File: rtl/devctl_datafile.sv
module devctl_datafile #(
    parameter int DW       = 16,
    parameter int NUM_DATA = 4,
    parameter logic [DW-1:0] READ_PATTERN = 16'hA5C3
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   wr_en,
    input  logic [$clog2(NUM_DATA > 1 ? NUM_DATA : 2)-1:0] wr_idx,
    input  logic [DW-1:0]          wr_data,
    input  logic                   fill_rd,
    output logic [NUM_DATA*DW-1:0] regs_flat
);

    localparam int IW = $clog2(NUM_DATA > 1 ? NUM_DATA : 2);

    for (genvar i = 0; i < NUM_DATA; i++) begin : g_word
        logic [DW-1:0] word_q;
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
                word_q <= '0;
            else if ((i == 0) && fill_rd)
                word_q <= READ_PATTERN;
            else if (wr_en && (wr_idx == IW'(i)))
                word_q <= wr_data;
        end
        assign regs_flat[i*DW +: DW] = word_q;
    end

endmodule

// File: rtl/devctl_regs.sv
module devctl_regs
    import devctl_pkg::*;
#(
    parameter int DW        = 16,
    parameter int NUM_DATA  = 4,
    parameter int ADDR_W    = 3,
    parameter int OP_CYCLES = 8,
    parameter logic [DW-1:0] READ_PATTERN = 16'hA5C3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DW-1:0]     wr_data,
    output logic [DW-1:0]     rd_data,
    output logic              irq_pending
);

    localparam int IW = $clog2(NUM_DATA > 1 ? NUM_DATA : 2);

    logic                   busy, done, fill_rd;
    logic [1:0]             err_code;
    logic [DW-1:0]          cur_cmd;
    logic [NUM_DATA*DW-1:0] regs_flat;
    logic                   hit_cmd, hit_stat, hit_data;
    logic [ADDR_W-1:0]      data_off;
    logic [IW-1:0]          data_idx;

    assign hit_cmd  = (addr == ADDR_W'(ADDR_CMD));
    assign hit_stat = (addr == ADDR_W'(ADDR_STAT));
    assign data_off = addr - ADDR_W'(DATA_BASE);
    assign hit_data = (addr >= ADDR_W'(DATA_BASE)) && (data_off < ADDR_W'(NUM_DATA));
    assign data_idx = IW'(data_off);

    devctl_fsm #(.DW(DW), .OP_CYCLES(OP_CYCLES)) u_fsm (
        .clk          (clk),
        .rst_n        (rst_n),
        .cmd_wr       (wr_en && hit_cmd),
        .cmd_code     (wr_data),
        .stat_wr      (wr_en && hit_stat),
        .stat_done_wr (wr_data[0]),
        .busy         (busy),
        .done         (done),
        .irq_pending  (irq_pending),
        .err_code     (err_code),
        .cur_cmd      (cur_cmd),
        .fill_rd      (fill_rd)
    );

    devctl_datafile #(.DW(DW), .NUM_DATA(NUM_DATA), .READ_PATTERN(READ_PATTERN)) u_data (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (wr_en && hit_data),
        .wr_idx    (data_idx),
        .wr_data   (wr_data),
        .fill_rd   (fill_rd),
        .regs_flat (regs_flat)
    );

    always_comb begin
        rd_data = '0;
        if (hit_cmd)
            rd_data = cur_cmd;
        else if (hit_stat)
            rd_data = DW'({err_code, busy, done});
        else if (hit_data)
            for (int i = 0; i < NUM_DATA; i++)
                if (data_idx == IW'(i)) rd_data = regs_flat[i*DW +: DW];
    end

    a_r3_no_busy_and_done: assert property (@(posedge clk) disable iff (!rst_n)
        !(busy && done));

    a_r8_read_fills_word0: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(done) && cur_cmd == DW'(CMD_READ)) |-> (regs_flat[DW-1:0] == READ_PATTERN));

    a_r4_irq_follows_done: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> irq_pending);

endmodule

// File: tb/tb_devctl_regs.sv
`timescale 1ns/1ps
module tb_devctl_regs;

    localparam int DW = 16;
    localparam int ND = 4;
    localparam int AW = 3;
    localparam int NC = 5;
    localparam logic [DW-1:0] PAT = 16'h3C5A;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          wr_en = 1'b0;
    logic [AW-1:0] addr = '0;
    logic [DW-1:0] wr_data = '0;
    logic [DW-1:0] rd_data;
    logic          irq_pending;

    devctl_regs #(.DW(DW), .NUM_DATA(ND), .ADDR_W(AW), .OP_CYCLES(NC), .READ_PATTERN(PAT)) dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr),
        .wr_data(wr_data), .rd_data(rd_data), .irq_pending(irq_pending)
    );

    always #10 clk = ~clk;

    int vectors = 0;
    int miscompares = 0;

    // behavioural reference: 0 idle, 1 working, 2 finished
    int mst = 0, mcnt = 0, merr = 0, mcmd = 0, mirq = 0;
    int mdata [ND];

    function automatic int exp_read(int a);
        if (a == 0) return mcmd;
        if (a == 1) return (merr << 2) | ((mst == 1) ? 2 : 0) | ((mst == 2) ? 1 : 0);
        if (a >= 2 && a < 2 + ND) return mdata[a-2];
        return 0;
    endfunction

    task automatic model_update(bit we, int a, int d);
        int old;
        bit fill;
        old = mst;
        fill = 0;
        if (old == 1) begin
            if (mcnt == 0) begin
                mst = 2; mirq = 1;
                if (mcmd == 1) fill = 1;
            end else mcnt--;
        end
        if (we) begin
            if (a == 0) begin
                if (old != 0) merr = 1;
                else if (d == 1 || d == 2) begin
                    mst = 1; mcnt = NC - 1; mcmd = d; merr = 0;
                end else merr = 2;
            end else if (a == 1) begin
                if (old == 2 && (d % 2) == 0) begin mst = 0; mirq = 0; end
            end else if (a >= 2 && a < 2 + ND) mdata[a-2] = d;
        end
        if (fill) mdata[0] = PAT;
    endtask

    task automatic step(string tag, bit we, int a, int d);
        int e;
        @(negedge clk);
        wr_en = we; addr = AW'(a); wr_data = DW'(d);
        #1;
        e = exp_read(a);
        vectors++;
        if (rd_data !== DW'(e) || irq_pending !== mirq[0]) begin
            miscompares++;
            $display("FAIL %s addr=%0d rd_data=%h irq=%b expected rd_data=%h irq=%0d",
                     tag, a, rd_data, irq_pending, DW'(e), mirq);
        end
        @(posedge clk);
        model_update(we, a, d);
    endtask

    task automatic idle_reads(string tag, int n, int a);
        for (int k = 0; k < n; k++) step(tag, 1'b0, a, 0);
    endtask

    initial begin
        #(200000 * 20);
        miscompares++;
        $display("FAIL watchdog expired: actual hung run, expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

    initial begin
        for (int i = 0; i < ND; i++) mdata[i] = 0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1 reset state of every address
        for (int a = 0; a < 8; a++) step("R1", 1'b0, a, 0);
        // R9 data write and readback, unmapped reads
        for (int i = 0; i < ND; i++) step("R9", 1'b1, 2 + i, 16'h1100 + i);
        for (int a = 2; a < 8; a++) step("R9", 1'b0, a, 0);
        step("R9", 1'b1, 7, 16'hFFFF);
        step("R9", 1'b0, 7, 0);
        // R10 status write while idle
        step("R10", 1'b1, 1, 1);
        step("R10", 1'b0, 1, 0);
        // R7 unknown command in idle
        step("R7", 1'b1, 0, 3);
        step("R7", 1'b0, 1, 0);
        step("R7", 1'b1, 0, 0);
        step("R7", 1'b0, 0, 0);
        // R2 WRITE accepted
        step("R2", 1'b1, 0, 2);
        step("R2", 1'b0, 1, 0);
        // R6 command during work, R10 status write during work
        step("R6", 1'b1, 0, 1);
        step("R6", 1'b0, 0, 0);
        step("R10", 1'b1, 1, 0);
        // R3 R4 run to completion
        idle_reads("R3", 4, 1);
        step("R4", 1'b0, 1, 0);
        // R8 WRITE leaves data alone
        for (int a = 2; a < 2 + ND; a++) step("R8", 1'b0, a, 0);
        // R6 command while finished
        step("R6", 1'b1, 0, 1);
        step("R6", 1'b0, 1, 0);
        // R5 done=1 has no effect, done=0 releases
        step("R5", 1'b1, 1, 1);
        step("R5", 1'b0, 1, 0);
        step("R5", 1'b1, 1, 0);
        step("R5", 1'b0, 1, 0);
        // R2 R8 READ with a data write landing in the completing cycle
        step("R2", 1'b1, 0, 1);
        step("R2", 1'b0, 0, 0);
        idle_reads("R3", 3, 1);
        step("R8", 1'b1, 2, 16'hBEEF);
        step("R8", 1'b0, 2, 0);
        step("R4", 1'b0, 1, 0);
        step("R9", 1'b1, 3, 16'h7777);
        step("R9", 1'b0, 3, 0);
        step("R5", 1'b1, 1, 0);
        step("R1", 1'b0, 1, 0);
        // R3 back-to-back READ after release, then R8 pattern restored
        step("R9", 1'b1, 2, 16'h0001);
        step("R2", 1'b1, 0, 1);
        idle_reads("R3", NC + 1, 1);
        step("R8", 1'b0, 2, 0);
        step("R5", 1'b1, 1, 0);
        step("R5", 1'b0, 1, 0);
        @(negedge clk);
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

endmodule